// File: doc/BRIEF.md
# Serial-In Latched Output Register

This block takes a bit stream on a serial data pin, clocked in by a separate shift clock pin, and holds the result as a bank of parallel drive-enable bits. A shift chain of `WIDTH` stages collects the bits. A latch bank copies the chain while a strobe pin is high and keeps its value once the strobe drops. A blanking pin switches every drive-enable bit off without touching what the latch holds. The last stage of the chain is brought out on a serial output, so several blocks can be chained on one data line.

All four input pins are asynchronous to the system clock. Each passes through a synchronizer of `SYNC_STAGES` flops. A shift happens on the detected rising edge of the synchronized shift clock. There is no valid/ready handshake and no back-pressure. The pins are plain level inputs, and the sender must hold each level for at least `SYNC_STAGES + 1` system clock cycles so that the synchronizer sees it. The serial output is a plain level that changes only when a shift occurs.

Top module: `ser_latch_drv`

## Requirements
- R1: While reset is high, the shift chain and the latch clear to all zeros and the blanking state is forced on. Once reset is released with the blanking pin high, `drv_en_o` is all zeros and `sdata_o` is 0.
- R2: On each detected rising edge of the synchronized shift clock, stage 0 takes the synchronized serial data bit and stage k takes the old value of stage k-1. Drive-enable bit i reflects stage i.
- R3: `sdata_o` always presents stage `WIDTH-1`. After `WIDTH` shifts it shows the first bit shifted in, and each further shift shows the next bit.
- R4: While the shift clock pin is not rising, changes on the serial data pin leave the chain and `sdata_o` unchanged.
- R5: While the strobe is high, the latch follows the shift chain one system cycle behind it, so shifts performed with the strobe high appear at the outputs.
- R6: While the strobe is low, the latch holds its value, and further shifts do not reach `drv_en_o`.
- R7: While the blanking pin is high, every bit of `drv_en_o` is 0 (off).
- R8: Blanking does not alter the latch. When blanking is released, the pattern that was latched before reappears.
- R9: While the blanking pin is low, `drv_en_o` bit i equals latch bit i, with 1 meaning on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sclk_i | input | 1 | Shift clock pin, asynchronous |
| sdata_i | input | 1 | Serial data pin, asynchronous |
| strobe_i | input | 1 | Latch strobe, latch transparent while high |
| blank_i | input | 1 | Blanking, all outputs off while high |
| sdata_o | output | 1 | Last chain stage, for cascading |
| drv_en_o | output | WIDTH | Drive-enable bits, 1 = on |

## Verification
The bench builds the block with its defaults, `WIDTH` = 20 and `SYNC_STAGES` = 2. With the full width, a complete load of 20 shifts brings the first bit to the cascade output, and a 21st shift checks the step to the next bit. The two-flop synchronizer sets a short latency, so each directed scenario can hold every pin level for a few cycles and then check a settled output. Runs of toggling data with the shift clock held still, shifts made with the strobe high and with it low, and shifts made during blanking all fit in a short run.

// File: rtl/ser_latch_pkg.sv
package ser_latch_pkg;

  // Raw control/data pins gathered so one synchronizer bank carries them all.
  typedef struct packed {
    logic sclk;
    logic strobe;
    logic blank;
    logic sdata;
  } sl_pins_t;

  localparam int SL_PIN_W = $bits(sl_pins_t);

  // Reset image of the synchronized pins: blanking asserted, rest low.
  localparam sl_pins_t SL_PIN_RST = '{sclk: 1'b0, strobe: 1'b0, blank: 1'b1, sdata: 1'b0};

endpackage

// File: rtl/sl_sync.sv
module sl_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/sl_shift.sv
module sl_shift #(
  parameter int WIDTH = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sclk_s,
  input  logic             din_s,
  output logic [WIDTH-1:0] chain,
  output logic             step
);

  logic sclk_prev;

  always_ff @(posedge clk) begin
    if (rst) sclk_prev <= 1'b0;
    else     sclk_prev <= sclk_s;
  end

  assign step = sclk_s & ~sclk_prev;

  generate
    if (WIDTH == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst)       chain <= '0;
        else if (step) chain <= din_s;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst)       chain <= '0;
        else if (step) chain <= {chain[WIDTH-2:0], din_s};
      end
      // R3
      tail_moves_chk: assert property (@(posedge clk) disable iff (rst)
        step |=> chain[WIDTH-1] == $past(chain[WIDTH-2]));
    end
  endgenerate

  // R2
  head_loads_chk: assert property (@(posedge clk) disable iff (rst)
    step |=> chain[0] == $past(din_s));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(chain));

endmodule

// File: rtl/sl_latch.sv
module sl_latch #(
  parameter int WIDTH = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             open_s,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)         q <= '0;
    else if (open_s) q <= d;
  end

  // R5
  follow_chk: assert property (@(posedge clk) disable iff (rst)
    open_s |=> q == $past(d));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !open_s |=> $stable(q));

endmodule

// File: rtl/ser_latch_drv.sv
module ser_latch_drv
  import ser_latch_pkg::*;
#(
  parameter int WIDTH       = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sclk_i,
  input  logic             sdata_i,
  input  logic             strobe_i,
  input  logic             blank_i,
  output logic             sdata_o,
  output logic [WIDTH-1:0] drv_en_o
);

  localparam int LAST = WIDTH - 1;

  sl_pins_t         pins_raw, pins_s;
  logic [SL_PIN_W-1:0] pins_s_vec;
  logic [WIDTH-1:0] chain, held;
  logic             step;

  assign pins_raw = '{sclk: sclk_i, strobe: strobe_i, blank: blank_i, sdata: sdata_i};

  sl_sync #(
    .WIDTH  (SL_PIN_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(SL_PIN_RST)
  ) u_sync (
    .clk(clk),
    .rst(rst),
    .d  (pins_raw),
    .q  (pins_s_vec)
  );

  assign pins_s = sl_pins_t'(pins_s_vec);

  sl_shift #(.WIDTH(WIDTH)) u_shift (
    .clk   (clk),
    .rst   (rst),
    .sclk_s(pins_s.sclk),
    .din_s (pins_s.sdata),
    .chain (chain),
    .step  (step)
  );

  sl_latch #(.WIDTH(WIDTH)) u_latch (
    .clk   (clk),
    .rst   (rst),
    .open_s(pins_s.strobe),
    .d     (chain),
    .q     (held)
  );

  assign sdata_o  = chain[LAST];
  assign drv_en_o = pins_s.blank ? '0 : held;

  // R8
  blank_keeps_latch_chk: assert property (@(posedge clk) disable iff (rst)
    (pins_s.blank && !pins_s.strobe) |=> $stable(held));

  // R3
  cascade_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(sdata_o));

endmodule

// File: tb/ser_latch_drv_bench.sv
module ser_latch_drv_bench;

  localparam int W = 20;

  logic clk = 1'b0;
  logic rst, sclk_i, sdata_i, strobe_i, blank_i;
  logic sdata_o;
  logic [W-1:0] drv_en_o;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  logic [W-1:0] m_chain, m_lat;
  logic [W-1:0] pat;

  always #5 clk = ~clk;

  ser_latch_drv #(.WIDTH(W), .SYNC_STAGES(2)) u_ser_latch_drv (
    .clk(clk), .rst(rst), .sclk_i(sclk_i), .sdata_i(sdata_i),
    .strobe_i(strobe_i), .blank_i(blank_i),
    .sdata_o(sdata_o), .drv_en_o(drv_en_o)
  );

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic check(string req, logic [W-1:0] got, logic [W-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic logic [W-1:0] expect_out();
    return blank_i ? '0 : m_lat;
  endfunction

  task automatic shift_bit(logic b);
    @(negedge clk); sdata_i = b;
    repeat (3) @(negedge clk); sclk_i = 1'b1;
    repeat (4) @(negedge clk); sclk_i = 1'b0;
    repeat (4) @(negedge clk);
    m_chain = {m_chain[W-2:0], b};
    if (strobe_i) m_lat = m_chain;
  endtask

  task automatic strobe_pulse();
    @(negedge clk); strobe_i = 1'b1;
    settle();
    m_lat = m_chain;
    strobe_i = 1'b0;
    settle();
  endtask

  task automatic t_reset();
    settle();
    check("R1 outputs off after reset", drv_en_o, '0);
    check("R1 cascade low after reset", {{(W-1){1'b0}}, sdata_o}, '0);
    blank_i = 1'b0;
    settle();
    check("R9 unblanked cleared latch", drv_en_o, '0);
  endtask

  task automatic t_load();
    pat = 20'hA5C3E;
    for (int i = W-1; i >= 0; i--) shift_bit(pat[i]);
    check("R6 no strobe keeps outputs", drv_en_o, '0);
    strobe_pulse();
    check("R2 full load pattern", drv_en_o, pat);
    check("R9 output equals latch", drv_en_o, expect_out());
    check("R3 cascade shows first bit", {{(W-1){1'b0}}, sdata_o}, {{(W-1){1'b0}}, pat[W-1]});
  endtask

  task automatic t_no_edge();
    for (int k = 0; k < 10; k++) begin
      @(negedge clk); sdata_i = k[0];
      repeat (3) @(negedge clk);
    end
    check("R4 cascade steady without edge", {{(W-1){1'b0}}, sdata_o}, {{(W-1){1'b0}}, pat[W-1]});
    strobe_pulse();
    check("R4 chain unchanged without edge", drv_en_o, pat);
  endtask

  task automatic t_cascade();
    shift_bit(1'b0);
    check("R3 cascade next bit", {{(W-1){1'b0}}, sdata_o}, {{(W-1){1'b0}}, pat[W-2]});
    check("R6 shift with strobe low hidden", drv_en_o, pat);
  endtask

  task automatic t_transparent();
    @(negedge clk); strobe_i = 1'b1;
    settle();
    m_lat = m_chain;
    check("R5 open latch shows chain", drv_en_o, m_chain);
    shift_bit(1'b1);
    settle();
    check("R5 shift passes through", drv_en_o, m_chain);
    shift_bit(1'b1);
    settle();
    check("R5 second shift passes through", drv_en_o, m_chain);
    @(negedge clk); strobe_i = 1'b0;
    settle();
    shift_bit(1'b0);
    settle();
    check("R6 closed latch holds", drv_en_o, m_lat);
  endtask

  task automatic t_blank();
    logic [W-1:0] saved;
    saved = m_lat;
    @(negedge clk); blank_i = 1'b1;
    settle();
    check("R7 blanked outputs off", drv_en_o, '0);
    shift_bit(1'b1);
    shift_bit(1'b0);
    check("R7 still off after shifts", drv_en_o, '0);
    check("R3 cascade while blanked", {{(W-1){1'b0}}, sdata_o}, {{(W-1){1'b0}}, m_chain[W-1]});
    @(negedge clk); blank_i = 1'b0;
    settle();
    check("R8 pattern restored", drv_en_o, saved);
    strobe_pulse();
    check("R9 new pattern after strobe", drv_en_o, m_chain);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    rst = 1'b1; sclk_i = 1'b0; sdata_i = 1'b0; strobe_i = 1'b0; blank_i = 1'b1;
    m_chain = '0; m_lat = '0; pat = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_load();
    t_no_edge();
    t_cascade();
    t_transparent();
    t_blank();
    report();
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired got=running exp=done");
    report();
  end

endmodule